// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Resolver with Vector Acknowledge

The block joins two 8-input request units into one 16-line interrupt source for a processor. Lines 0 to 7 feed the primary unit and lines 8 to 15 feed the secondary unit. Bit 3 of a line number picks the unit and bits 2:0 pick the pin inside it. Each unit latches a request when its line shows a rising edge. A request stays latched until it is acknowledged, whatever the line does afterwards. While the secondary unit holds any request, the primary unit's pin 2 receives a request. The processor sees one interrupt output, and that output is high whenever the primary unit holds a request.

The processor acknowledges with a one-cycle strobe. The block then resolves the primary unit first. If pin 2 wins there, it goes on to resolve the secondary unit. The block returns an 8-bit vector and the 4-bit number of the line it serviced. Each vector is a unit base plus a pin. The two bases are parameters, and only their upper five bits are used. The acknowledge clears the serviced request, so in-service state is retired automatically. When nothing real is waiting at a level, the block reports a defined spurious vector for that level.

Top module: `cvack_top`

## Requirements
- R1: A request on a line is latched when the line is sampled high after being sampled low. A line held high latches no new request. A line falling does not remove a latched request. Lines 0-7 belong to the primary unit and lines 8-15 to the secondary unit.
- R2: While the secondary unit holds any request, primary pin 2 holds a request, so `int_o` is high in the same cycle.
- R3: `int_o` is high exactly when the primary unit holds at least one request. It is updated at the clock edge after any change, including the edge of an acknowledge.
- R4: Inside each unit the lowest-numbered latched pin wins.
- R5: If an acknowledge finds a primary winner other than pin 2, the outputs become `vec_o` = primary base + pin and `line_o` = pin. That request is cleared.
- R6: If the primary winner is pin 2 and the secondary unit holds a request, the secondary winner is serviced. The outputs become `vec_o` = secondary base + pin and `line_o` = pin + 8. Both the primary pin-2 request and the secondary request are cleared.
- R7: If the primary winner is pin 2 and the secondary unit holds nothing, the acknowledge is spurious at the secondary level. The outputs become `vec_o` = secondary base + 7 and `line_o` = 15. Only the primary pin-2 request is cleared.
- R8: If an acknowledge finds the primary unit empty, the outputs become `vec_o` = primary base + 7 and `line_o` = 7. No request changes.
- R9: Only bits 7:3 of each base parameter are used. Bits 2:0 of `vec_o` always equal bits 2:0 of `line_o`.
- R10: Reset clears all requests and sets `vec_o` and `line_o` to zero. Between acknowledges, `vec_o` and `line_o` hold their values.
- R11: When an acknowledge clears a pin in the same cycle that a new edge arrives on that pin, the new request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | Request lines, edge sensed |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| int_o | output | 1 | Interrupt to the processor |
| vec_o | output | 8 | Vector of the last acknowledge |
| line_o | output | 4 | Line number of the last acknowledge |

## Verification
A wrong latched-request bit shows up in one of two ways. It may change `int_o` at the very next edge. Otherwise it shows up at the next acknowledge, as a wrong line number or a wrong vector. Comparing against a reference model on every clock therefore catches it within one cycle of the next acknowledge. A lost secondary-to-primary forward shows up at once as `int_o` staying low while only a secondary line is pending. The spurious vectors for both levels, and the cases where an edge arrives in the same cycle as the acknowledge that clears it, are driven on purpose so that they are not left to chance.

// File: rtl/cvack_pkg.sv
package cvack_pkg;
    localparam int UNIT_W    = 8;
    localparam int PIN_W     = $clog2(UNIT_W);
    localparam int LINE_W    = PIN_W + 1;
    localparam int VEC_W     = 8;
    localparam int CASC_PIN  = 2;
    localparam int SPUR_PIN  = UNIT_W - 1;

    typedef logic [UNIT_W-1:0] pin_mask_t;
    typedef logic [PIN_W-1:0]  pin_t;

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [LINE_W-1:0] line;
    } ack_result_t;

    function automatic pin_t lowest_pin(input pin_mask_t m);
        pin_t r;
        r = '0;
        for (int i = UNIT_W - 1; i >= 0; i--) begin
            if (m[i]) r = pin_t'(i);
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] make_vec(input logic [VEC_W-1:0] base, input pin_t p);
        return {base[VEC_W-1:PIN_W], p};
    endfunction
endpackage

// File: rtl/cvack_unit.sv
module cvack_unit
    import cvack_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mask_t req_i,
    input  logic      fwd_i,
    input  logic      clr_i,
    input  pin_t      clr_pin_i,
    output logic      pend_o,
    output pin_t      win_o,
    output logic      pend_next_o
);
    pin_mask_t lat_q, prev_q, rise, clr_mask, fwd_mask, lat_n;

    always_comb begin
        rise     = req_i & ~prev_q;
        clr_mask = clr_i ? pin_mask_t'(1) << clr_pin_i : '0;
        fwd_mask = fwd_i ? pin_mask_t'(1) << CASC_PIN : '0;
        lat_n    = (lat_q & ~clr_mask) | rise | fwd_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q  <= '0;
            prev_q <= '0;
        end else begin
            lat_q  <= lat_n;
            prev_q <= req_i;
        end
    end

    assign pend_o      = |lat_q;
    assign win_o       = lowest_pin(lat_q);
    assign pend_next_o = |lat_n;
endmodule

// File: rtl/cvack_decode.sv
module cvack_decode
    import cvack_pkg::*;
#(
    parameter logic [VEC_W-1:0] MASTER_BASE = 8'h08,
    parameter logic [VEC_W-1:0] SLAVE_BASE  = 8'h70
) (
    input  logic        ack_i,
    input  logic        m_pend_i,
    input  pin_t        m_win_i,
    input  logic        s_pend_i,
    input  pin_t        s_win_i,
    output logic        m_clr_o,
    output logic        s_clr_o,
    output ack_result_t res_o
);
    localparam pin_t SPUR = pin_t'(SPUR_PIN);
    localparam pin_t CASC = pin_t'(CASC_PIN);

    always_comb begin
        m_clr_o   = 1'b0;
        s_clr_o   = 1'b0;
        res_o.line = {1'b0, SPUR};
        res_o.vec  = make_vec(MASTER_BASE, SPUR);
        if (ack_i && m_pend_i) begin
            m_clr_o = 1'b1;
            if (m_win_i != CASC) begin
                res_o.line = {1'b0, m_win_i};
                res_o.vec  = make_vec(MASTER_BASE, m_win_i);
            end else if (s_pend_i) begin
                s_clr_o    = 1'b1;
                res_o.line = {1'b1, s_win_i};
                res_o.vec  = make_vec(SLAVE_BASE, s_win_i);
            end else begin
                res_o.line = {1'b1, SPUR};
                res_o.vec  = make_vec(SLAVE_BASE, SPUR);
            end
        end
    end
endmodule

// File: rtl/cvack_top.sv
module cvack_top
    import cvack_pkg::*;
#(
    parameter logic [VEC_W-1:0] MASTER_BASE = 8'h08,
    parameter logic [VEC_W-1:0] SLAVE_BASE  = 8'h70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2*UNIT_W-1:0] req_i,
    input  logic              ack_i,
    output logic              int_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [LINE_W-1:0] line_o
);
    logic        m_pend, s_pend, s_pend_next, m_clr, s_clr, m_unused_next;
    pin_t        m_win, s_win;
    ack_result_t res;

    cvack_unit u_slave (
        .clk(clk), .rst(rst), .req_i(req_i[2*UNIT_W-1:UNIT_W]), .fwd_i(1'b0),
        .clr_i(s_clr), .clr_pin_i(s_win), .pend_o(s_pend), .win_o(s_win),
        .pend_next_o(s_pend_next)
    );

    cvack_unit u_master (
        .clk(clk), .rst(rst), .req_i(req_i[UNIT_W-1:0]), .fwd_i(s_pend_next),
        .clr_i(m_clr), .clr_pin_i(m_win), .pend_o(m_pend), .win_o(m_win),
        .pend_next_o(m_unused_next)
    );

    cvack_decode #(.MASTER_BASE(MASTER_BASE), .SLAVE_BASE(SLAVE_BASE)) u_dec (
        .ack_i(ack_i), .m_pend_i(m_pend), .m_win_i(m_win), .s_pend_i(s_pend),
        .s_win_i(s_win), .m_clr_o(m_clr), .s_clr_o(s_clr), .res_o(res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_o  <= '0;
            line_o <= '0;
        end else if (ack_i) begin
            vec_o  <= res.vec;
            line_o <= res.line;
        end
    end

    assign int_o = m_pend;
endmodule

// File: rtl/cvack_chk.sv
module cvack_chk
    import cvack_pkg::*;
#(
    parameter logic [VEC_W-1:0] MB = 8'h08,
    parameter logic [VEC_W-1:0] SB = 8'h70
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_i,
    input logic              int_o,
    input logic [VEC_W-1:0]  vec_o,
    input logic [LINE_W-1:0] line_o,
    input logic              s_pend
);
    a_r2_slave_forward: assert property (@(posedge clk) disable iff (rst)
        s_pend |-> int_o);

    a_r8_empty_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !int_o) |=> (line_o == LINE_W'(SPUR_PIN)) &&
                              (vec_o == {MB[VEC_W-1:PIN_W], pin_t'(SPUR_PIN)}));

    a_r9_low_bits: assert property (@(posedge clk) disable iff (rst)
        vec_o[PIN_W-1:0] == line_o[PIN_W-1:0]);

    a_r9_base_select: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> (line_o[PIN_W] ? (vec_o[VEC_W-1:PIN_W] == SB[VEC_W-1:PIN_W])
                                 : (vec_o[VEC_W-1:PIN_W] == MB[VEC_W-1:PIN_W])));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> $stable(vec_o) && $stable(line_o));
endmodule

bind cvack_top cvack_chk #(.MB(MASTER_BASE), .SB(SLAVE_BASE)) u_chk (
    .clk(clk), .rst(rst), .ack_i(ack_i), .int_o(int_o), .vec_o(vec_o),
    .line_o(line_o), .s_pend(s_pend)
);

// File: tb/cvack_top_tb.sv
`timescale 1ns/1ps
module cvack_top_tb;
    localparam logic [7:0] MB_P = 8'h23;
    localparam logic [7:0] SB_P = 8'h75;
    localparam logic [7:0] MB = 8'h20;
    localparam logic [7:0] SB = 8'h70;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req_i = '0;
    logic        ack_i = 1'b0;
    logic        int_o;
    logic [7:0]  vec_o;
    logic [3:0]  line_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // behavioural reference state
    bit [7:0]  mp, sp;
    bit [15:0] prev;
    bit [7:0]  e_vec;
    bit [3:0]  e_line;
    string     tag = "R10";

    cvack_top #(.MASTER_BASE(MB_P), .SLAVE_BASE(SB_P)) u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i),
        .int_o(int_o), .vec_o(vec_o), .line_o(line_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        bit [15:0] rise;
        int w;
        if (rst) begin
            mp = 0; sp = 0; prev = 0; e_vec = 0; e_line = 0; tag = "R10";
        end else begin
            rise = req_i & ~prev;
            prev = req_i;
            if (ack_i) begin
                if (mp == 0) begin
                    e_vec = MB + 7; e_line = 7; tag = "R8";
                end else begin
                    w = 0;
                    while (!mp[w]) w++;
                    mp[w] = 0;
                    if (w != 2) begin
                        e_vec = MB + 8'(w); e_line = 4'(w); tag = "R5";
                    end else if (sp != 0) begin
                        w = 0;
                        while (!sp[w]) w++;
                        sp[w] = 0;
                        e_vec = SB + 8'(w); e_line = 4'(w + 8); tag = "R6";
                    end else begin
                        e_vec = SB + 7; e_line = 15; tag = "R7";
                    end
                end
            end
            sp = sp | rise[15:8];
            mp = mp | rise[7:0];
            if (sp != 0) mp[2] = 1'b1;
        end
    end

    task automatic chk(input string r, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", r, got, exp);
        end
    endtask

    // compare every cycle against the reference, then drive next inputs
    task automatic cyc(input logic [15:0] r, input logic a);
        @(negedge clk);
        cycles++;
        chk((sp != 0) ? "R2" : "R3", int_o, (mp != 0));
        chk(tag, vec_o, e_vec);
        chk(tag, line_o, e_line);
        req_i = r;
        ack_i = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        repeat (3) cyc(16'h0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", {int_o, vec_o, line_o}, 0);
        cyc(16'h0, 1'b1);                       // R8 empty acknowledge
        cyc(16'h0, 1'b0);
        chk("R8", line_o, 7); chk("R9", vec_o, 8'h27);
        cyc(16'h0022, 1'b0);                    // R1 lines 1 and 5 rise
        cyc(16'h0022, 1'b0);
        chk("R1", int_o, 1);
        cyc(16'h0000, 1'b1);                    // R4 lowest wins
        cyc(16'h0000, 1'b0);
        chk("R4", line_o, 1); chk("R5", vec_o, 8'h21);
        chk("R1", int_o, 1);                    // falling line keeps request 5
        cyc(16'h0000, 1'b1);
        cyc(16'h0000, 1'b0);
        chk("R5", line_o, 5); chk("R3", int_o, 0);
        cyc(16'h1000, 1'b0);                    // line 12
        cyc(16'h1000, 1'b0);
        chk("R2", int_o, 1);
        cyc(16'h1000, 1'b1);
        cyc(16'h1000, 1'b0);
        chk("R6", line_o, 12); chk("R9", vec_o, 8'h74);
        chk("R1", int_o, 0);                    // held line gives no new request
        cyc(16'h4200, 1'b0);                    // lines 9 and 14
        cyc(16'h0000, 1'b1);
        cyc(16'h0000, 1'b0);
        chk("R6", line_o, 9); chk("R2", int_o, 1);
        cyc(16'h0000, 1'b1);
        cyc(16'h0000, 1'b0);
        chk("R6", line_o, 14); chk("R3", int_o, 0);
        cyc(16'h0004, 1'b0);                    // external line 2, empty secondary
        cyc(16'h0000, 1'b1);
        cyc(16'h0000, 1'b0);
        chk("R7", line_o, 15); chk("R7", vec_o, 8'h77);
        cyc(16'h0008, 1'b0);                    // line 3
        cyc(16'h0000, 1'b0);
        cyc(16'h0008, 1'b1);                    // R11 ack with same-pin edge
        cyc(16'h0000, 1'b0);
        chk("R11", int_o, 1); chk("R5", line_o, 3);
        cyc(16'h0000, 1'b1);
        cyc(16'h0000, 1'b0);
        chk("R11", line_o, 3); chk("R3", int_o, 0);
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf & 16'h5A5B ^ {lf[7:0], lf[15:8]} & 16'h2424, (lf[3:0] == 4'h5));
        end
        repeat (40) cyc(16'h0, 1'b1);
        cyc(16'h0, 1'b0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule